// File: doc/BRIEF.md
# PHY Management Event Counter Registers

This block is a slice of the management register file of an Ethernet physical-layer device. It keeps three registers: an auto-negotiation expansion status word, a 16-bit count of link disconnects and a 16-bit count of false-carrier events. False-carrier events are cases where carrier sense is raised without a start-of-stream delimiter. The link logic reports each event to the block as a single-cycle pulse. The partner's next-page and auto-negotiation capabilities arrive as level inputs.

Software reaches the registers through a simple synchronous port. The port carries a 5-bit address, a read strobe, a write strobe and 16-bit write and read data. Read data is registered: it appears on the cycle after the strobe and holds until the next read. Reading a counter returns the count since the previous read and clears the counter. Reading the expansion word clears its latched fault flag. Reading the link-partner ability address, which lives outside this slice, clears the page-received flag.

The two counters overflow differently. The disconnect counter wraps around. The false-carrier counter sticks at its maximum value.

Top module: `phy_evt_regs`

## Requirements
- R1: A read of address 06h returns the expansion word. Bits 15:5 are 0 and bit 2 (own next-page capability) is 0. Bit 3 is `lp_np_capable` and bit 0 is `lp_an_capable`, both taken in the strobe cycle.
- R2: Bit 4 of the expansion word (link fault) sets one cycle after an `evt_link_fault` pulse. It stays set until a read of 06h, which returns 1 and clears it.
- R3: Bit 1 of the expansion word (page received) sets after an `evt_page_rx` pulse. A read of address 05h clears it. A read of 06h leaves it set.
- R4: When a set pulse for bit 4 or bit 1 arrives in the same cycle as the read that clears that bit, the bit stays set.
- R5: The disconnect counter at 12h counts `evt_disconnect` pulses. It wraps from FFFFh to 0000h.
- R6: The false-carrier counter at 13h counts `evt_false_carrier` pulses. It holds at FFFFh once it reaches that value.
- R7: A read of 12h or 13h returns the current count and leaves the counter at 0.
- R8: When an event pulse arrives in the same cycle as a clearing read of its counter, the read returns the old count and the counter is left at 1.
- R9: A write to 06h has no effect. A write to 12h or 13h loads that counter with the write data. When both strobes are high in one cycle, the read is performed and the write is dropped.
- R10: A read of any address other than 06h, 12h and 13h returns 0000h. Address 05h is included.
- R11: Read data changes only on the clock edge that samples a read strobe. Between reads it holds its value while events continue.
- R12: Asserting `rst_n` low clears both counters, both latched flags and the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | 5 | Register address |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| evt_disconnect | input | 1 | Link disconnect event pulse |
| evt_false_carrier | input | 1 | Carrier sense without start delimiter, event pulse |
| evt_page_rx | input | 1 | New link code word page received, event pulse |
| evt_link_fault | input | 1 | Multiple link fault detected, event pulse |
| lp_np_capable | input | 1 | Link partner supports next pages |
| lp_an_capable | input | 1 | Link partner supports auto-negotiation |

## Verification
Any wrong counter or flag state inside the block can be seen at the ports, but only on the cycle after the next read of the matching address. So each check has to read the register right after the stimulus. A lost or doubled event shows up as an off-by-one count. A wrong overflow policy shows up as 0000h where FFFFh is expected, or the other way round. A clear-on-read that misses a coincident event shows up as 0 on the following read instead of 1. A flag cleared by the wrong address shows up in bits 4 and 1 of the next expansion read.

// File: rtl/phy_evt_pkg.sv
package phy_evt_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 16;

  localparam logic [ADDR_W-1:0] ADDR_LP_ABIL = 5'h05;
  localparam logic [ADDR_W-1:0] ADDR_AN_EXP  = 5'h06;
  localparam logic [ADDR_W-1:0] ADDR_DISC    = 5'h12;
  localparam logic [ADDR_W-1:0] ADDR_FALSE   = 5'h13;

  localparam int unsigned NUM_CNT  = 2;
  localparam int unsigned CNT_DISC = 0;
  localparam int unsigned CNT_FALS = 1;

  typedef struct packed {
    logic [DATA_W-6:0] zero_hi;
    logic              link_fault;
    logic              lp_next_page;
    logic              own_next_page;
    logic              page_rcvd;
    logic              lp_autoneg;
  } an_exp_word_t;
endpackage

// File: rtl/phy_rst_sync.sv
module phy_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/phy_evt_counter.sv
module phy_evt_counter #(
  parameter int unsigned WIDTH    = 16,
  parameter bit          SATURATE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             rd_clr,
  input  logic             ld,
  input  logic [WIDTH-1:0] ld_val,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] CNT_MAX = '1;
  localparam logic [WIDTH-1:0] CNT_ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q, cnt_d, cnt_inc;
  logic             cnt_en;

  generate
    if (SATURATE) begin : g_sat
      assign cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_ONE;
    end else begin : g_wrap
      assign cnt_inc = cnt_q + CNT_ONE;
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    if (rd_clr) begin
      cnt_d = evt ? CNT_ONE : '0;
    end else if (ld) begin
      cnt_d = ld_val;
    end else if (evt) begin
      cnt_d = cnt_inc;
    end
  end

  assign cnt_en = evt | rd_clr | ld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/phy_sticky_flag.sv
module phy_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_d = set | (flag_q & ~clr);
  end

  assign flag_en = set | clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/phy_evt_regs.sv
module phy_evt_regs
  import phy_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              evt_disconnect,
  input  logic              evt_false_carrier,
  input  logic              evt_page_rx,
  input  logic              evt_link_fault,
  input  logic              lp_np_capable,
  input  logic              lp_an_capable
);
  logic srst_n;

  phy_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // Address decode
  logic hit_lp, hit_exp;
  logic [NUM_CNT-1:0] hit_cnt;
  assign hit_lp           = (reg_addr == ADDR_LP_ABIL);
  assign hit_exp          = (reg_addr == ADDR_AN_EXP);
  assign hit_cnt[CNT_DISC] = (reg_addr == ADDR_DISC);
  assign hit_cnt[CNT_FALS] = (reg_addr == ADDR_FALSE);

  logic              wr_eff;
  assign wr_eff = reg_wr & ~reg_rd;

  // Counters: one wrapping, one saturating
  logic [NUM_CNT-1:0]             cnt_evt;
  logic [NUM_CNT-1:0][DATA_W-1:0] cnt_val;
  assign cnt_evt[CNT_DISC] = evt_disconnect;
  assign cnt_evt[CNT_FALS] = evt_false_carrier;

  generate
    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
      phy_evt_counter #(
        .WIDTH    (DATA_W),
        .SATURATE (gi == CNT_FALS)
      ) u_cnt (
        .clk    (clk),
        .rst_n  (srst_n),
        .evt    (cnt_evt[gi]),
        .rd_clr (reg_rd & hit_cnt[gi]),
        .ld     (wr_eff & hit_cnt[gi]),
        .ld_val (reg_wdata),
        .count  (cnt_val[gi])
      );
    end
  endgenerate

  // Latched status flags
  logic fault_flag, page_flag;

  phy_sticky_flag u_fault_flag (
    .clk   (clk),
    .rst_n (srst_n),
    .set   (evt_link_fault),
    .clr   (reg_rd & hit_exp),
    .flag  (fault_flag)
  );

  phy_sticky_flag u_page_flag (
    .clk   (clk),
    .rst_n (srst_n),
    .set   (evt_page_rx),
    .clr   (reg_rd & hit_lp),
    .flag  (page_flag)
  );

  // Expansion word assembly
  an_exp_word_t exp_word;
  always_comb begin
    exp_word               = '0;
    exp_word.link_fault    = fault_flag;
    exp_word.lp_next_page  = lp_np_capable;
    exp_word.own_next_page = 1'b0;
    exp_word.page_rcvd     = page_flag;
    exp_word.lp_autoneg    = lp_an_capable;
  end

  // Read mux and registered read data
  logic [DATA_W-1:0] rdata_d, rdata_q;

  always_comb begin
    rdata_d = '0;
    if (hit_exp) begin
      rdata_d = exp_word;
    end else if (hit_cnt[CNT_DISC]) begin
      rdata_d = cnt_val[CNT_DISC];
    end else if (hit_cnt[CNT_FALS]) begin
      rdata_d = cnt_val[CNT_FALS];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      rdata_q <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/phy_evt_regs_chk.sv
module phy_evt_regs_chk
  import phy_evt_pkg::*;
(
  input logic              clk,
  input logic              srst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              evt_disconnect,
  input logic              evt_false_carrier,
  input logic              evt_page_rx,
  input logic              evt_link_fault,
  input logic              lp_np_capable,
  input logic              lp_an_capable,
  input logic [DATA_W-1:0] dcnt,
  input logic [DATA_W-1:0] fcnt,
  input logic              fault_flag,
  input logic              page_flag
);
  logic rd_exp, rd_dc, rd_fc, rd_unmapped;
  assign rd_exp = reg_rd && reg_addr == ADDR_AN_EXP;
  assign rd_dc  = reg_rd && reg_addr == ADDR_DISC;
  assign rd_fc  = reg_rd && reg_addr == ADDR_FALSE;
  assign rd_unmapped = reg_rd && !(reg_addr == ADDR_AN_EXP || reg_addr == ADDR_DISC
                                   || reg_addr == ADDR_FALSE);

  AST_EXP_FIXED_BITS: assert property (@(posedge clk) disable iff (!srst_n)
    rd_exp |=> (reg_rdata[15:5] == '0 && !reg_rdata[2] &&
                reg_rdata[3] == $past(lp_np_capable) &&
                reg_rdata[0] == $past(lp_an_capable))); // R1
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!srst_n)
    (fault_flag && !rd_exp) |=> fault_flag); // R2
  AST_PAGE_SURVIVES_EXP_RD: assert property (@(posedge clk) disable iff (!srst_n)
    (page_flag && rd_exp) |=> page_flag); // R3
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!srst_n)
    (evt_page_rx || evt_link_fault) |=> ((page_flag || !$past(evt_page_rx)) &&
                                         (fault_flag || !$past(evt_link_fault)))); // R4
  AST_DISC_WRAPS: assert property (@(posedge clk) disable iff (!srst_n)
    (dcnt == 16'hFFFF && evt_disconnect && !rd_dc && !(reg_wr && reg_addr == ADDR_DISC))
    |=> dcnt == 16'h0000); // R5
  AST_FALSE_SATURATES: assert property (@(posedge clk) disable iff (!srst_n)
    (fcnt == 16'hFFFF && evt_false_carrier && !rd_fc && !(reg_wr && reg_addr == ADDR_FALSE))
    |=> fcnt == 16'hFFFF); // R6
  AST_RD_RETURNS_COUNT: assert property (@(posedge clk) disable iff (!srst_n)
    rd_dc |=> reg_rdata == $past(dcnt)); // R7
  AST_RD_KEEPS_EVENT: assert property (@(posedge clk) disable iff (!srst_n)
    rd_fc |=> fcnt == ($past(evt_false_carrier) ? 16'd1 : 16'd0)); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    rd_unmapped |=> reg_rdata == '0); // R10
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!srst_n)
    !reg_rd |=> $stable(reg_rdata)); // R11
endmodule

bind phy_evt_regs phy_evt_regs_chk u_chk (
  .clk               (clk),
  .srst_n            (srst_n),
  .reg_addr          (reg_addr),
  .reg_rd            (reg_rd),
  .reg_wr            (reg_wr),
  .reg_rdata         (reg_rdata),
  .evt_disconnect    (evt_disconnect),
  .evt_false_carrier (evt_false_carrier),
  .evt_page_rx       (evt_page_rx),
  .evt_link_fault    (evt_link_fault),
  .lp_np_capable     (lp_np_capable),
  .lp_an_capable     (lp_an_capable),
  .dcnt              (cnt_val[0]),
  .fcnt              (cnt_val[1]),
  .fault_flag        (fault_flag),
  .page_flag         (page_flag)
);

// File: tb/phy_evt_regs_tb_top.sv
module phy_evt_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  reg_addr;
  logic        reg_rd, reg_wr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        evt_disconnect, evt_false_carrier, evt_page_rx, evt_link_fault;
  logic        lp_np_capable, lp_an_capable;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Bench-side expected state
  logic [15:0] m_d, m_f, m_last;
  logic        m_pg, m_mlf;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_evt_regs dut_i (
    .clk               (clk),
    .rst_n             (rst_n),
    .reg_addr          (reg_addr),
    .reg_rd            (reg_rd),
    .reg_wr            (reg_wr),
    .reg_wdata         (reg_wdata),
    .reg_rdata         (reg_rdata),
    .evt_disconnect    (evt_disconnect),
    .evt_false_carrier (evt_false_carrier),
    .evt_page_rx       (evt_page_rx),
    .evt_link_fault    (evt_link_fault),
    .lp_np_capable     (lp_np_capable),
    .lp_an_capable     (lp_an_capable)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %04h expected %04h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  function automatic logic [15:0] expect_read(input logic [4:0] a);
    case (a)
      5'h06:   return {11'b0, m_mlf, lp_np_capable, 1'b0, m_pg, lp_an_capable};
      5'h12:   return m_d;
      5'h13:   return m_f;
      default: return 16'h0000;
    endcase
  endfunction

  // One bus cycle; ev = {link_fault, page_rx, false_carrier, disconnect}
  task automatic access(input logic [4:0] a, input logic r, input logic w,
                        input logic [15:0] wd, input logic [3:0] ev, input string tag);
    logic [15:0] exp;
    exp = expect_read(a);
    @(negedge clk);
    reg_addr = a; reg_rd = r; reg_wr = w; reg_wdata = wd;
    {evt_link_fault, evt_page_rx, evt_false_carrier, evt_disconnect} = ev;
    @(negedge clk);
    reg_rd = 1'b0; reg_wr = 1'b0;
    {evt_link_fault, evt_page_rx, evt_false_carrier, evt_disconnect} = 4'b0;
    if (r) begin
      check(tag, reg_rdata, exp);
      m_last = exp;
    end
    // expected state after the cycle
    if (r && a == 5'h12)      m_d = ev[0] ? 16'd1 : 16'd0;
    else if (w && a == 5'h12) m_d = wd;
    else if (ev[0])           m_d = m_d + 16'd1;
    if (r && a == 5'h13)      m_f = ev[1] ? 16'd1 : 16'd0;
    else if (w && a == 5'h13) m_f = wd;
    else if (ev[1] && m_f != 16'hFFFF) m_f = m_f + 16'd1;
    m_pg  = ev[2] | (m_pg  & ~(r && a == 5'h05));
    m_mlf = ev[3] | (m_mlf & ~(r && a == 5'h06));
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_d = '0; m_f = '0; m_pg = 1'b0; m_mlf = 1'b0; m_last = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    reg_addr = '0; reg_rd = 0; reg_wr = 0; reg_wdata = '0;
    evt_disconnect = 0; evt_false_carrier = 0; evt_page_rx = 0; evt_link_fault = 0;
    lp_np_capable = 0; lp_an_capable = 0;
    apply_reset();

    // R12: reset state
    check("R12 rdata after reset", reg_rdata, 16'h0000);
    access(5'h12, 1, 0, 0, 4'b0, "R12 disc count after reset");
    access(5'h13, 1, 0, 0, 4'b0, "R12 false count after reset");
    access(5'h06, 1, 0, 0, 4'b0, "R12 expansion after reset");

    // R1: partner capability bits, all four combinations
    for (int c = 0; c < 4; c++) begin
      lp_np_capable = c[1]; lp_an_capable = c[0];
      access(5'h06, 1, 0, 0, 4'b0, "R1 expansion partner bits");
    end
    lp_np_capable = 1; lp_an_capable = 1;

    // R5 / R6 / R7: count sweeps, read clears
    for (int n = 0; n < 24; n++) begin
      for (int k = 0; k < n; k++) access(5'h00, 0, 0, 0, 4'b0001, "R5 pulse");
      access(5'h12, 1, 0, 0, 4'b0, "R5 R7 disconnect count");
      for (int k = 0; k < n; k++) access(5'h00, 0, 0, 0, 4'b0010, "R6 pulse");
      access(5'h13, 1, 0, 0, 4'b0, "R6 R7 false count");
    end
    access(5'h12, 1, 0, 0, 4'b0, "R7 disconnect cleared");
    access(5'h13, 1, 0, 0, 4'b0, "R7 false cleared");

    // R5 wrap, R6 saturation via preload (R9)
    access(5'h12, 0, 1, 16'hFFFD, 4'b0, "R9 load disc");
    for (int k = 0; k < 5; k++) access(5'h00, 0, 0, 0, 4'b0001, "R5 pulse");
    access(5'h12, 1, 0, 0, 4'b0, "R5 wrap past FFFF");
    access(5'h13, 0, 1, 16'hFFFD, 4'b0, "R9 load false");
    for (int k = 0; k < 5; k++) access(5'h00, 0, 0, 0, 4'b0010, "R6 pulse");
    access(5'h13, 1, 0, 0, 4'b0, "R6 saturate at FFFF");
    access(5'h13, 1, 0, 0, 4'b0, "R7 false cleared after saturation");

    // R8: event coincident with clearing read
    access(5'h12, 0, 1, 16'h0042, 4'b0, "R9 load disc");
    access(5'h12, 1, 0, 0, 4'b0001, "R8 disc read with event");
    access(5'h12, 1, 0, 0, 4'b0, "R8 disc left at one");
    access(5'h13, 0, 1, 16'h0007, 4'b0, "R9 load false");
    access(5'h13, 1, 0, 0, 4'b0010, "R8 false read with event");
    access(5'h13, 1, 0, 0, 4'b0, "R8 false left at one");

    // R9: write to expansion ignored, read beats write
    access(5'h00, 0, 0, 0, 4'b1000, "R2 fault pulse");
    access(5'h06, 0, 1, 16'hFFFF, 4'b0, "R9 write expansion");
    access(5'h06, 1, 0, 0, 4'b0, "R9 R2 expansion after write");
    access(5'h12, 0, 1, 16'h1234, 4'b0, "R9 load disc");
    access(5'h12, 1, 1, 16'hABCD, 4'b0, "R9 read with write");
    access(5'h12, 1, 0, 0, 4'b0, "R9 write dropped");

    // R2: fault latch and clear
    access(5'h06, 1, 0, 0, 4'b0, "R2 fault cleared");
    access(5'h00, 0, 0, 0, 4'b1000, "R2 fault pulse");
    access(5'h12, 1, 0, 0, 4'b0, "R2 unrelated read");
    access(5'h06, 1, 0, 0, 4'b0, "R2 fault still set");
    access(5'h06, 1, 0, 0, 4'b0, "R2 fault cleared by read");

    // R3: page flag cleared only by 05h
    access(5'h00, 0, 0, 0, 4'b0100, "R3 page pulse");
    access(5'h06, 1, 0, 0, 4'b0, "R3 page set");
    access(5'h06, 1, 0, 0, 4'b0, "R3 page survives expansion read");
    access(5'h05, 1, 0, 0, 4'b0, "R3 R10 read 05h");
    access(5'h06, 1, 0, 0, 4'b0, "R3 page cleared by 05h");

    // R4: set wins over clear
    access(5'h00, 0, 0, 0, 4'b1100, "R4 set both");
    access(5'h06, 1, 0, 0, 4'b1000, "R4 fault clear with set");
    access(5'h05, 1, 0, 0, 4'b0100, "R4 page clear with set");
    access(5'h06, 1, 0, 0, 4'b0, "R4 both still set");

    // R10: address sweep with known contents
    access(5'h12, 0, 1, 16'h0007, 4'b0, "R9 load disc");
    access(5'h13, 0, 1, 16'h0009, 4'b0, "R9 load false");
    access(5'h00, 0, 0, 0, 4'b1100, "R10 set flags");
    for (int a = 0; a < 32; a++) begin
      access(5'(a), 1, 0, 0, 4'b0, "R10 address sweep");
    end

    // R11: read data holds between reads while events arrive
    access(5'h12, 0, 1, 16'h5A5A, 4'b0, "R9 load disc");
    access(5'h12, 1, 0, 0, 4'b0, "R11 read");
    for (int k = 0; k < 4; k++) begin
      access(5'h12, 0, 0, 0, 4'b1111, "R11 idle with events");
      check("R11 rdata held", reg_rdata, m_last);
    end

    // R12: reset mid-run
    access(5'h00, 0, 0, 0, 4'b1111, "R12 events before reset");
    apply_reset();
    check("R12 rdata after second reset", reg_rdata, 16'h0000);
    lp_np_capable = 0; lp_an_capable = 0;
    access(5'h06, 1, 0, 0, 4'b0, "R12 flags after second reset");
    access(5'h12, 1, 0, 0, 4'b0, "R12 disc after second reset");
    access(5'h13, 1, 0, 0, 4'b0, "R12 false after second reset");

    finish_run();
  end
endmodule